// File: doc/BRIEF.md
# Registered Transmit Port with Parity Generation

This block is the sending half of a registered bidirectional port. A producer on the A side presents a word and pulses a load strobe. If the active-low load enable is LOW, the word is stored and a ready flag rises to tell the consumer that new data is waiting. The consumer pulls its active-low output enable LOW to read. While that enable is LOW, the port drives the stored word and a generated parity bit. When the consumer releases the enable (a LOW-to-HIGH change), the ready flag drops, which completes a demand-response handshake.

Everything runs on one system clock. The strobe and the output enable are asynchronous to that clock, so they pass through synchroniser chains and are edge-detected. The load enable and the A word pass through a matching delay line, so the values used are the ones present alongside the strobe. The three-state pad is modelled as a data bus plus a drive-enable output. Data and parity read as zero whenever the drive is off.

Top module: `regtx_port`

## Requirements
- R1: A rising edge of `ld_strobe` while `ld_ce_n` is 0 stores the `a_data` word that was present with the strobe.
- R2: A rising edge of `ld_strobe` while `ld_ce_n` is 1 leaves the stored word unchanged.
- R3: Every load sets `word_ready` to 1.
- R4: A rising edge (0 to 1) of `rd_oe_n` clears `word_ready` to 0.
- R5: While `rd_oe_n` is settled at 1, `b_drive_en`, `b_data` and `b_parity` are all 0. While it is settled at 0, `b_drive_en` is 1 and `b_data` equals the stored word.
- R6: While driving, `b_parity` is 1 when the stored word holds an even number of ones (zero included) and 0 when the count is odd, so the nine driven bits hold an odd number of ones.
- R7: `word_ready` keeps its value in any cycle with neither a load nor a rising edge of `rd_oe_n`. A strobe edge with `ld_cE_n` at 1 does not count as a load.
- R8: When a load and a rising edge of `rd_oe_n` are detected in the same cycle, the load wins and `word_ready` ends at 1.
- R9: Synchronous active-high `rst` clears the stored word, `word_ready` and all B-side outputs.
- R10: With `SYNC_STAGES` = 2 and `rd_oe_n` held at 0, a new word appears on `b_data` at the fourth clock edge after the first edge that samples `ld_strobe` high, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_data | input | DATA_W | Word from the A side |
| ld_strobe | input | 1 | Load strobe; acts on its rising edge |
| ld_ce_n | input | 1 | Active-low load enable |
| rd_oe_n | input | 1 | Active-low B-side output enable; its rising edge clears the flag |
| b_data | output | DATA_W | Driven word, 0 while not driving |
| b_parity | output | 1 | Generated parity bit, 0 while not driving |
| b_drive_en | output | 1 | 1 while the B pads would be driven |
| word_ready | output | 1 | Ready flag for the consumer |

## Verification
A wrong ready-flag state shows on `word_ready` one clock edge after the detected event, because the flag drives the port directly. A corrupted stored word stays hidden while the output enable is high. It appears on `b_data` and `b_parity` only one edge after the driven state has been synchronised, so the checks that compare the word and its parity are made with the port enabled, both after loads and across enable cycles. The one-edge latency window and the same-cycle load-and-release case are covered by directed cases, because random traffic hits them rarely.

// File: rtl/txp_pkg.sv
package txp_pkg;

  localparam int unsigned TXP_MIN_SYNC = 2;

  typedef enum logic [1:0] {
    FLG_HOLD  = 2'd0,
    FLG_SET   = 2'd1,
    FLG_CLEAR = 2'd2
  } flag_evt_e;

  // Load outranks the reader's release.
  function automatic flag_evt_e flag_decide(input logic load, input logic release_edge);
    if (load)              return FLG_SET;
    else if (release_edge) return FLG_CLEAR;
    else                   return FLG_HOLD;
  endfunction

endpackage

// File: rtl/txp_edge_sync.sv
module txp_edge_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {(STAGES+1){RST_VAL}};
    else     sr <= {sr[STAGES-1:0], din};
  end

  assign lvl  = sr[STAGES-1];
  assign rise = sr[STAGES-1] & ~sr[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R10
endmodule

// File: rtl/txp_align_pipe.sv
module txp_align_pipe #(
  parameter int unsigned       W       = 9,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/txp_word_reg.sv
module txp_word_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/txp_ready_flag.sv
module txp_ready_flag
  import txp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic release_edge,
  output logic flag
);
  flag_evt_e evt;

  always_comb evt = flag_decide(load, release_edge);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else begin
      unique case (evt)
        FLG_SET:   flag <= 1'b1;
        FLG_CLEAR: flag <= 1'b0;
        default:   flag <= flag;
      endcase
    end
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
    load |=> flag); // R3
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (release_edge && !load) |=> !flag); // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!release_edge && !load) |=> $stable(flag)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (release_edge && load) |=> flag); // R8
endmodule

// File: rtl/txp_out_stage.sv
module txp_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         drive,
  input  logic [W-1:0] word,
  output logic [W-1:0] b_data,
  output logic         b_parity,
  output logic         b_drive_en
);
  logic par_fill;

  always_comb par_fill = ~(^word);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_data     <= '0;
      b_parity   <= 1'b0;
      b_drive_en <= 1'b0;
    end else begin
      b_drive_en <= drive;
      b_data     <= drive ? word : '0;
      b_parity   <= drive & par_fill;
    end
  end

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !b_drive_en |-> (b_data == '0 && !b_parity)); // R5
  AST_DRIVE_WORD: assert property (@(posedge clk) disable iff (rst)
    b_drive_en |-> (b_data == $past(word))); // R5
  AST_ODD_TOTAL: assert property (@(posedge clk) disable iff (rst)
    b_drive_en |-> (^{b_data, b_parity})); // R6
endmodule

// File: rtl/regtx_port.sv
module regtx_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_data,
  input  logic              ld_strobe,
  input  logic              ld_ce_n,
  input  logic              rd_oe_n,
  output logic [DATA_W-1:0] b_data,
  output logic              b_parity,
  output logic              b_drive_en,
  output logic              word_ready
);
  import txp_pkg::*;

  localparam int unsigned PIPE_W = DATA_W + 1;
  localparam logic [PIPE_W-1:0] PIPE_RST = {1'b1, {DATA_W{1'b0}}};

  logic              ld_lvl, ld_rise;
  logic              oe_lvl, oe_rise;
  logic [PIPE_W-1:0] aligned;
  logic              ce_n_d;
  logic [DATA_W-1:0] data_d;
  logic              do_load;
  logic [DATA_W-1:0] word_q;

  initial begin
    if (SYNC_STAGES < TXP_MIN_SYNC) $error("SYNC_STAGES below minimum");
  end

  txp_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ld_sync (
    .clk(clk), .rst(rst), .din(ld_strobe), .lvl(ld_lvl), .rise(ld_rise)
  );

  txp_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_oe_sync (
    .clk(clk), .rst(rst), .din(rd_oe_n), .lvl(oe_lvl), .rise(oe_rise)
  );

  txp_align_pipe #(.W(PIPE_W), .STAGES(SYNC_STAGES), .RST_VAL(PIPE_RST)) u_align (
    .clk(clk), .rst(rst), .din({ld_ce_n, a_data}), .dout(aligned)
  );

  assign ce_n_d  = aligned[DATA_W];
  assign data_d  = aligned[DATA_W-1:0];
  assign do_load = ld_rise & ~ce_n_d;

  txp_word_reg #(.W(DATA_W)) u_word (
    .clk(clk), .rst(rst), .load(do_load), .d(data_d), .q(word_q)
  );

  txp_ready_flag u_flag (
    .clk(clk), .rst(rst), .load(do_load), .release_edge(oe_rise), .flag(word_ready)
  );

  txp_out_stage #(.W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .drive(~oe_lvl), .word(word_q),
    .b_data(b_data), .b_parity(b_parity), .b_drive_en(b_drive_en)
  );

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (word_q == $past(data_d))); // R1
  AST_DISABLED_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (ld_rise && ce_n_d) |=> $stable(word_q)); // R2
endmodule

// File: tb/regtx_port_bench.sv
module regtx_port_bench;
  localparam int unsigned W      = 8;
  localparam time         CLK_PER = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_data;
  logic         ld_strobe, ld_ce_n, rd_oe_n;
  logic [W-1:0] b_data;
  logic         b_parity, b_drive_en, word_ready;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] exp_word;
  logic         exp_flag;
  logic         oe_now;

  always #(CLK_PER/2) clk = ~clk;

  regtx_port #(.DATA_W(W), .SYNC_STAGES(2)) u_regtx_port (
    .clk(clk), .rst(rst), .a_data(a_data), .ld_strobe(ld_strobe),
    .ld_ce_n(ld_ce_n), .rd_oe_n(rd_oe_n), .b_data(b_data),
    .b_parity(b_parity), .b_drive_en(b_drive_en), .word_ready(word_ready)
  );

  function automatic logic exp_par(input logic [W-1:0] d);
    return ~(^d);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic check_port(input string tag);
    chk({tag, " ready"}, word_ready, exp_flag);
    chk({tag, " drive"}, b_drive_en, !oe_now);
    chk({tag, " data"}, b_data, oe_now ? '0 : exp_word);
    chk({tag, " parity"}, b_parity, oe_now ? 1'b0 : exp_par(exp_word));
  endtask

  task automatic do_load(input logic [W-1:0] d, input logic ce_n, input string tag);
    @(negedge clk);
    a_data = d; ld_ce_n = ce_n; ld_strobe = 1'b1;
    cycles(5);
    @(negedge clk);
    ld_strobe = 1'b0;
    cycles(4);
    if (!ce_n) begin exp_word = d; exp_flag = 1'b1; end
    check_port(tag);
  endtask

  task automatic set_oe(input logic v, input string tag);
    @(negedge clk);
    if (oe_now == 1'b0 && v == 1'b1) exp_flag = 1'b0;
    rd_oe_n = v; oe_now = v;
    cycles(5);
    check_port(tag);
  endtask

  initial begin
    #(CLK_PER * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst = 1'b1; a_data = '0; ld_strobe = 1'b0; ld_ce_n = 1'b1; rd_oe_n = 1'b1;
    oe_now = 1'b1; exp_word = '0; exp_flag = 1'b0;
    cycles(4);
    @(negedge clk); rst = 1'b0;
    cycles(1);
    check_port("R9 reset");
    set_oe(1'b0, "R9 cleared word");

    // R1 R3 R5 R6 directed loads while driving
    do_load(8'h00, 1'b0, "R6 zero word");
    do_load(8'h01, 1'b0, "R6 one bit");
    do_load(8'hFF, 1'b0, "R6 all ones");
    do_load(8'h7F, 1'b0, "R1 seven ones");
    // R2 disabled strobe changes nothing (word and flag, R7)
    do_load(8'hA5, 1'b1, "R2 R7 disabled load");
    set_oe(1'b1, "R4 release clears");
    set_oe(1'b0, "R5 drive again");
    do_load(8'h3C, 1'b1, "R7 disabled keeps flag low");

    // R10 latency with port driven
    do_load(8'h11, 1'b0, "R10 setup");
    @(negedge clk);
    a_data = 8'hE2; ld_ce_n = 1'b0; ld_strobe = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    chk("R10 before window", b_data, 8'h11);
    @(posedge clk); #1;
    chk("R10 at window", b_data, 8'hE2);
    @(negedge clk); ld_strobe = 1'b0;
    exp_word = 8'hE2; exp_flag = 1'b1;
    cycles(4);
    check_port("R10 settle");

    // R8 load and release detected together
    set_oe(1'b1, "R8 prep release");
    set_oe(1'b0, "R8 prep drive");
    @(negedge clk);
    a_data = 8'h96; ld_ce_n = 1'b0; ld_strobe = 1'b1; rd_oe_n = 1'b1; oe_now = 1'b1;
    cycles(5);
    @(negedge clk); ld_strobe = 1'b0;
    cycles(4);
    exp_word = 8'h96; exp_flag = 1'b1;
    check_port("R8 load wins");
    set_oe(1'b0, "R8 word visible");

    // random mix
    for (int k = 0; k < 60; k++) begin
      int unsigned r;
      r = $urandom;
      if (r[1:0] != 2'd0) do_load(W'($urandom), r[2] & r[3], "R1 R3 random load");
      else                set_oe(~oe_now, "R4 R5 random oe");
    end

    // R9 reset mid-run
    do_load(8'h5A, 1'b0, "R9 pre");
    @(negedge clk); rst = 1'b1;
    cycles(2);
    @(negedge clk); rst = 1'b0;
    cycles(1);
    exp_word = '0; exp_flag = 1'b0;
    chk("R9 ready after reset", word_ready, 1'b0);
    chk("R9 data after reset", b_data, '0);
    cycles(4);
    check_port("R9 word cleared");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule